// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm Compare

This block keeps wall-clock time and calendar date as a chain of BCD counters. It is advanced by a one-cycle `tick` pulse that the surrounding logic produces once every hundredth of a second. The chain covers hundredths, seconds, minutes, hours, day of week, day of month, a three-digit day of year, month and a two-digit year. Hours run either on a 24-hour dial or on a 12-hour dial with a PM flag.

Every field sits at a byte address and is read and written through one register port. The read path is combinational. Writes take effect on the next clock edge. Writing any time field other than hundredths zeroes the hundredths count, so a newly set time starts cleanly at the top of its second.

A compare bank holds one byte for each field, plus a field-enable mask. The `alarm` output is high for as long as every enabled field equals its compare byte.

Top module: `bcd_rtc_calendar`

## Requirements
- R1: After reset the fields read hundredths 00, seconds 00, minutes 00, hour 00 on the 24-hour dial, weekday 1, date 01, day of year 001, month 01 and year 00. All compare bytes and the mask read 00, and `alarm` is low.
- R2: Each `tick` adds one to the hundredths (address 0x00) in BCD. A tick at 99 gives 00 and carries into the seconds. Without a tick or a write, no field changes.
- R3: Seconds (0x01) and minutes (0x02) count 00 to 59. Each wraps to 00 and carries into the next field.
- R4: With mode bit 0 of address 0x0A clear, the hour byte (0x03) counts 00 to 23. The wrap from 23 to 00 advances the day.
- R5: With mode bit 0 set, hour bits 5:0 hold BCD 01 to 12 and bit 7 is PM. The step from 11 to 12 flips PM, and 12 steps to 01. The step from 11 PM to 12 AM advances the day.
- R6: The weekday (0x04, bits 3:0) counts 1 to 7 and returns to 1 on each day advance.
- R7: The date (0x05) wraps after the last day of its month and advances the month (0x08). April, June, September and November have 30 days, February has 28 (29 in a leap year), and the other months have 31. Month 12 wraps to 01 and advances the year (0x09), which runs 00 to 99 and then wraps.
- R8: The day of year is kept as tens/units at 0x06 and hundreds at 0x07 (bits 3:0). It counts 001 to 365, or to 366 in a leap year, and then returns to 001. A year is a leap year when its BCD value is divisible by four.
- R9: A write to addresses 0x01 to 0x09 loads that field and clears the hundredths. A write to 0x00 loads the hundredths. A tick in the same cycle as a time-field write is dropped, but a tick that coincides with any other write still counts.
- R10: `rdData` shows the byte at `addr` in the same cycle. This covers the fields, the mode byte, the compare bytes at 0x10+field and the mask at 0x1E/0x1F.
- R11: Mask bits 7:0 at 0x1E enable fields 0 to 7, and bits 1:0 at 0x1F enable fields 8 and 9. `alarm` is high exactly when the mask is non-zero and every enabled field equals its compare byte. In 12-hour mode the hour byte is compared together with its PM bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per hundredth of a second |
| wrEn | input | 1 | Register write strobe |
| addr | input | 5 | Register address for reads and writes |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Byte at `addr` |
| alarm | output | 1 | High while all enabled fields match their compare bytes |

## Verification
The assertions assume that software writes only legal BCD values for each field: seconds and minutes no higher than 59, a weekday from 1 to 7, and the hundreds digit of the day of year within 0 to 3. The range properties therefore hold only while that stays true. The stimulus writes only legal calendar values. It presets fields just short of a rollover rather than ticking through long spans. It selects a dial before writing an hour, because switching the mode bit does not convert a stored hour.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 5;
  localparam int NUM_FIELDS = 10;
  localparam int MASK_HI_W  = NUM_FIELDS - DATA_W;

  localparam int FLD_HSEC  = 0;
  localparam int FLD_SEC   = 1;
  localparam int FLD_MIN   = 2;
  localparam int FLD_HOUR  = 3;
  localparam int FLD_DOW   = 4;
  localparam int FLD_DOM   = 5;
  localparam int FLD_DOYLO = 6;
  localparam int FLD_DOYHI = 7;
  localparam int FLD_MONTH = 8;
  localparam int FLD_YEAR  = 9;

  localparam logic [ADDR_W-1:0] ADDR_MODE    = 5'h0A;
  localparam logic [ADDR_W-1:0] CMP_BASE     = 5'h10;
  localparam logic [ADDR_W-1:0] ADDR_MASK_LO = 5'h1E;
  localparam logic [ADDR_W-1:0] ADDR_MASK_HI = 5'h1F;

  typedef struct packed {
    logic [NUM_FIELDS-1:0] fieldWr;
    logic [NUM_FIELDS-1:0] cmpWr;
    logic                  modeWr;
    logic                  maskLoWr;
    logic                  maskHiWr;
    logic                  advance;
  } rtcStrobe_t;

  // two-digit BCD increment, 99 wraps to 00
  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'd9) begin
      if (v[7:4] == 4'd9) r = 8'h00;
      else                r = {4'(v[7:4] + 4'd1), 4'd0};
    end else begin
      r = {v[7:4], 4'(v[3:0] + 4'd1)};
    end
    return r;
  endfunction

  // BCD year divisible by four
  function automatic logic isLeap(input logic [7:0] y);
    logic r;
    if (y[4] == 1'b0) r = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    else              r = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return r;
  endfunction
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output rtcStrobe_t        strobe
);
  always_comb begin
    strobe = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      strobe.fieldWr[i] = wrEn && (addr == ADDR_W'(i));
      strobe.cmpWr[i]   = wrEn && (addr == CMP_BASE + ADDR_W'(i));
    end
    strobe.modeWr   = wrEn && (addr == ADDR_MODE);
    strobe.maskLoWr = wrEn && (addr == ADDR_MASK_LO);
    strobe.maskHiWr = wrEn && (addr == ADDR_MASK_HI);
    // a time-field write takes precedence over a tick
    strobe.advance  = tick && !(|strobe.fieldWr);
  end
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  rtcStrobe_t                        strobe,
  input  logic [DATA_W-1:0]                 wrData,
  output logic                              mode12,
  output logic [NUM_FIELDS-1:0][DATA_W-1:0] fieldVal
);
  logic [7:0] hsec, sec, minute, dom, doyLo, month, year;
  logic [5:0] hour;
  logic       pm;
  logic [3:0] dow, doyHi;

  logic       hsecWrap, secWrap, minWrap, dayEnd, dayCarry;
  logic       leapNow, domWrap, monthWrap, doyWrap;
  logic [5:0] hourNext;
  logic       pmNext;
  logic [7:0] hourInc, monthLen;
  logic [11:0] doyNext, doyLast;

  always_comb begin
    hsecWrap = (hsec == 8'h99);
    secWrap  = hsecWrap && (sec == 8'h59);
    minWrap  = secWrap && (minute == 8'h59);
    hourInc  = bcdInc({2'b00, hour});
    hourNext = hourInc[5:0];
    pmNext   = pm;
    dayEnd   = 1'b0;
    if (mode12) begin
      if (hour == 6'h11) begin
        hourNext = 6'h12;
        pmNext   = ~pm;
        dayEnd   = pm;
      end else if (hour == 6'h12) begin
        hourNext = 6'h01;
      end
    end else if (hour == 6'h23) begin
      hourNext = 6'h00;
      dayEnd   = 1'b1;
    end
    dayCarry = minWrap && dayEnd;

    leapNow = isLeap(year);
    case (month)
      8'h02:                      monthLen = leapNow ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: monthLen = 8'h30;
      default:                    monthLen = 8'h31;
    endcase
    domWrap   = (dom == monthLen);
    monthWrap = (month == 8'h12);

    doyLast = leapNow ? 12'h366 : 12'h365;
    doyWrap = ({doyHi, doyLo} == doyLast);
    if (doyWrap)              doyNext = 12'h001;
    else if (doyLo == 8'h99)  doyNext = {4'(doyHi + 4'd1), 8'h00};
    else                      doyNext = {doyHi, bcdInc(doyLo)};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsec <= 8'h00; sec <= 8'h00; minute <= 8'h00;
      hour <= 6'h00; pm <= 1'b0; mode12 <= 1'b0;
      dow <= 4'd1; dom <= 8'h01; doyLo <= 8'h01; doyHi <= 4'd0;
      month <= 8'h01; year <= 8'h00;
    end else begin
      if (strobe.modeWr) mode12 <= wrData[0];
      if (|strobe.fieldWr) begin
        hsec <= strobe.fieldWr[FLD_HSEC] ? wrData : 8'h00;
        if (strobe.fieldWr[FLD_SEC])   sec    <= wrData;
        if (strobe.fieldWr[FLD_MIN])   minute <= wrData;
        if (strobe.fieldWr[FLD_HOUR]) begin
          hour <= wrData[5:0];
          pm   <= wrData[7];
        end
        if (strobe.fieldWr[FLD_DOW])   dow    <= wrData[3:0];
        if (strobe.fieldWr[FLD_DOM])   dom    <= wrData;
        if (strobe.fieldWr[FLD_DOYLO]) doyLo  <= wrData;
        if (strobe.fieldWr[FLD_DOYHI]) doyHi  <= wrData[3:0];
        if (strobe.fieldWr[FLD_MONTH]) month  <= wrData;
        if (strobe.fieldWr[FLD_YEAR])  year   <= wrData;
      end else if (strobe.advance) begin
        hsec <= bcdInc(hsec);
        if (hsecWrap) sec    <= (sec == 8'h59) ? 8'h00 : bcdInc(sec);
        if (secWrap)  minute <= (minute == 8'h59) ? 8'h00 : bcdInc(minute);
        if (minWrap) begin
          hour <= hourNext;
          pm   <= pmNext;
        end
        if (dayCarry) begin
          dow   <= (dow == 4'd7) ? 4'd1 : 4'(dow + 4'd1);
          dom   <= domWrap ? 8'h01 : bcdInc(dom);
          doyLo <= doyNext[7:0];
          doyHi <= doyNext[11:8];
          if (domWrap) begin
            month <= monthWrap ? 8'h01 : bcdInc(month);
            if (monthWrap) year <= bcdInc(year);
          end
        end
      end
    end
  end

  always_comb begin
    fieldVal            = '0;
    fieldVal[FLD_HSEC]  = hsec;
    fieldVal[FLD_SEC]   = sec;
    fieldVal[FLD_MIN]   = minute;
    fieldVal[FLD_HOUR]  = {pm & mode12, 1'b0, hour};
    fieldVal[FLD_DOW]   = {4'd0, dow};
    fieldVal[FLD_DOM]   = dom;
    fieldVal[FLD_DOYLO] = doyLo;
    fieldVal[FLD_DOYHI] = {4'd0, doyHi};
    fieldVal[FLD_MONTH] = month;
    fieldVal[FLD_YEAR]  = year;
  end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  rtcStrobe_t                        strobe,
  input  logic [DATA_W-1:0]                 wrData,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [NUM_FIELDS-1:0][DATA_W-1:0] fieldVal,
  output logic [DATA_W-1:0]                 cmpRd,
  output logic [NUM_FIELDS-1:0]             maskVal,
  output logic                              alarm
);
  logic [NUM_FIELDS-1:0][DATA_W-1:0] cmpReg;
  logic [NUM_FIELDS-1:0]             fieldHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpReg  <= '0;
      maskVal <= '0;
    end else begin
      for (int i = 0; i < NUM_FIELDS; i++)
        if (strobe.cmpWr[i]) cmpReg[i] <= wrData;
      if (strobe.maskLoWr) maskVal[DATA_W-1:0]          <= wrData;
      if (strobe.maskHiWr) maskVal[NUM_FIELDS-1:DATA_W] <= wrData[MASK_HI_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : gHit
    assign fieldHit[g] = !maskVal[g] || (cmpReg[g] == fieldVal[g]);
  end

  assign alarm = (|maskVal) && (&fieldHit);

  always_comb begin
    cmpRd = '0;
    if (addr == ADDR_MASK_LO) cmpRd = maskVal[DATA_W-1:0];
    if (addr == ADDR_MASK_HI) cmpRd = {{(DATA_W-MASK_HI_W){1'b0}}, maskVal[NUM_FIELDS-1:DATA_W]};
    for (int i = 0; i < NUM_FIELDS; i++)
      if (addr == CMP_BASE + ADDR_W'(i)) cmpRd = cmpReg[i];
  end
endmodule

// File: rtl/bcd_rtc_calendar.sv
module bcd_rtc_calendar
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              alarm
);
  rtcStrobe_t                        strobe;
  logic [NUM_FIELDS-1:0][DATA_W-1:0] fieldVal;
  logic [NUM_FIELDS-1:0]             maskVal;
  logic [DATA_W-1:0]                 cmpRd;
  logic                              mode12;

  rtc_ctrl i_ctrl (.tick(tick), .wrEn(wrEn), .addr(addr), .strobe(strobe));

  rtc_datapath i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .mode12(mode12), .fieldVal(fieldVal)
  );

  rtc_alarm i_alarm (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .addr(addr),
    .fieldVal(fieldVal), .cmpRd(cmpRd), .maskVal(maskVal), .alarm(alarm)
  );

  always_comb begin
    rdData = cmpRd;
    if (addr == ADDR_MODE) rdData = {{(DATA_W-1){1'b0}}, mode12};
    for (int i = 0; i < NUM_FIELDS; i++)
      if (addr == ADDR_W'(i)) rdData = fieldVal[i];
  end
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
  import rtc_pkg::*;
(
  input logic                              clk,
  input logic                              rstN,
  input logic                              tick,
  input logic                              wrEn,
  input logic [ADDR_W-1:0]                 addr,
  input rtcStrobe_t                        strobe,
  input logic [NUM_FIELDS-1:0][DATA_W-1:0] fieldVal,
  input logic [NUM_FIELDS-1:0]             maskVal,
  input logic                              alarm
);
  a_r9_tick_dropped_on_field_write: assert property (@(posedge clk) disable iff (!rstN)
    (tick && wrEn && (addr < ADDR_W'(NUM_FIELDS))) |-> !strobe.advance);

  a_r9_write_clears_hsec: assert property (@(posedge clk) disable iff (!rstN)
    (|strobe.fieldWr[NUM_FIELDS-1:1]) |=> (fieldVal[FLD_HSEC] == 8'h00));

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.advance && !(|strobe.fieldWr) && !strobe.modeWr) |=> $stable(fieldVal));

  a_r2_hsec_steps_up: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && fieldVal[FLD_HSEC] != 8'h99) |=> (fieldVal[FLD_HSEC] > $past(fieldVal[FLD_HSEC])));

  a_r3_sec_waits_for_carry: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && fieldVal[FLD_HSEC] != 8'h99) |=> $stable(fieldVal[FLD_SEC]));

  a_r3_sec_range: assert property (@(posedge clk) disable iff (!rstN)
    (fieldVal[FLD_SEC] <= 8'h59) && (fieldVal[FLD_SEC][3:0] <= 4'd9));

  a_r6_dow_range: assert property (@(posedge clk) disable iff (!rstN)
    (fieldVal[FLD_DOW] >= 8'h01) && (fieldVal[FLD_DOW] <= 8'h07));

  a_r11_alarm_needs_mask: assert property (@(posedge clk) disable iff (!rstN)
    alarm |-> (|maskVal));
endmodule

bind bcd_rtc_calendar rtc_checker i_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
  .strobe(strobe), .fieldVal(fieldVal), .maskVal(maskVal), .alarm(alarm)
);

// File: tb/test_bcd_rtc_calendar.sv
`timescale 1ns/1ps
module test_bcd_rtc_calendar;
  logic       clk = 1'b0, rstN = 1'b0, tick = 1'b0, wrEn = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       alarm;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  bcd_rtc_calendar i_bcd_rtc_calendar (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .alarm(alarm)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic chkReg(input string tag, input logic [4:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; #1;
    chk(tag, rdData, exp);
  endtask

  task automatic chkAlarm(input string tag, input logic exp);
    @(negedge clk); #1;
    chk(tag, {7'd0, alarm}, {7'd0, exp});
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  // place the clock one tick before the hour boundary
  task automatic preEnd(input logic [7:0] hourByte);
    wr(5'h03, hourByte); wr(5'h02, 8'h59); wr(5'h01, 8'h59); wr(5'h00, 8'h99);
  endtask

  task automatic testReset();
    chkReg("R1 hsec", 5'h00, 8'h00); chkReg("R1 sec", 5'h01, 8'h00);
    chkReg("R1 min", 5'h02, 8'h00);  chkReg("R1 hour", 5'h03, 8'h00);
    chkReg("R1 dow", 5'h04, 8'h01);  chkReg("R1 dom", 5'h05, 8'h01);
    chkReg("R1 doyLo", 5'h06, 8'h01); chkReg("R1 doyHi", 5'h07, 8'h00);
    chkReg("R1 month", 5'h08, 8'h01); chkReg("R1 year", 5'h09, 8'h00);
    chkReg("R1 mask", 5'h1E, 8'h00); chkReg("R1 cmp", 5'h13, 8'h00);
    chkAlarm("R1 alarm", 1'b0);
  endtask

  task automatic testHundredths();
    ticks(5);
    chkReg("R2 five ticks", 5'h00, 8'h05);
    repeat (6) @(negedge clk);
    chkReg("R2 idle hold", 5'h00, 8'h05);
    wr(5'h00, 8'h09); ticks(1);
    chkReg("R2 digit carry", 5'h00, 8'h10);
  endtask

  task automatic testCascade();
    preEnd(8'h00); ticks(1);
    chkReg("R2 hsec wrap", 5'h00, 8'h00);
    chkReg("R3 sec wrap", 5'h01, 8'h00);
    chkReg("R3 min wrap", 5'h02, 8'h00);
    chkReg("R4 hour step", 5'h03, 8'h01);
  endtask

  task automatic testDayEnd24();
    wr(5'h04, 8'h07); wr(5'h05, 8'h15); wr(5'h08, 8'h03); wr(5'h09, 8'h23);
    wr(5'h06, 8'h74); wr(5'h07, 8'h00);
    preEnd(8'h23); ticks(1);
    chkReg("R4 midnight", 5'h03, 8'h00);
    chkReg("R6 dow wrap", 5'h04, 8'h01);
    chkReg("R7 dom step", 5'h05, 8'h16);
    chkReg("R8 doy step", 5'h06, 8'h75);
  endtask

  task automatic testTwelveHour();
    wr(5'h0A, 8'h01);
    chkReg("R10 mode read", 5'h0A, 8'h01);
    preEnd(8'h11); ticks(1);
    chkReg("R5 11am to 12pm", 5'h03, 8'h92);
    preEnd(8'h92); ticks(1);
    chkReg("R5 12pm to 1pm", 5'h03, 8'h81);
    wr(5'h04, 8'h03);
    preEnd(8'h91); ticks(1);
    chkReg("R5 11pm to 12am", 5'h03, 8'h12);
    chkReg("R5 day advance", 5'h04, 8'h04);
    wr(5'h0A, 8'h00);
  endtask

  task automatic dayEndMonth(input logic [7:0] y, input logic [7:0] m, input logic [7:0] d);
    wr(5'h09, y); wr(5'h08, m); wr(5'h05, d); preEnd(8'h23); ticks(1);
  endtask

  task automatic testMonths();
    dayEndMonth(8'h23, 8'h02, 8'h28);
    chkReg("R7 feb28 dom", 5'h05, 8'h01); chkReg("R7 feb28 month", 5'h08, 8'h03);
    dayEndMonth(8'h24, 8'h02, 8'h28);
    chkReg("R7 leap feb29", 5'h05, 8'h29); chkReg("R7 leap month", 5'h08, 8'h02);
    preEnd(8'h23); ticks(1);
    chkReg("R7 leap mar1", 5'h05, 8'h01); chkReg("R7 leap mar", 5'h08, 8'h03);
    dayEndMonth(8'h23, 8'h04, 8'h30);
    chkReg("R7 apr30", 5'h05, 8'h01); chkReg("R7 may", 5'h08, 8'h05);
    dayEndMonth(8'h23, 8'h01, 8'h30);
    chkReg("R7 jan31", 5'h05, 8'h31);
    preEnd(8'h23); ticks(1);
    chkReg("R7 feb1", 5'h08, 8'h02);
    dayEndMonth(8'h99, 8'h12, 8'h31);
    chkReg("R7 newyear dom", 5'h05, 8'h01); chkReg("R7 newyear month", 5'h08, 8'h01);
    chkReg("R7 year wrap", 5'h09, 8'h00);
  endtask

  task automatic dayEndDoy(input logic [7:0] y, input logic [7:0] hi, input logic [7:0] lo);
    wr(5'h05, 8'h10); wr(5'h09, y); wr(5'h07, hi); wr(5'h06, lo); preEnd(8'h23); ticks(1);
  endtask

  task automatic testDayOfYear();
    dayEndDoy(8'h23, 8'h03, 8'h65);
    chkReg("R8 365 wrap hi", 5'h07, 8'h00); chkReg("R8 365 wrap lo", 5'h06, 8'h01);
    dayEndDoy(8'h24, 8'h03, 8'h65);
    chkReg("R8 leap 366 hi", 5'h07, 8'h03); chkReg("R8 leap 366 lo", 5'h06, 8'h66);
    preEnd(8'h23); ticks(1);
    chkReg("R8 366 wrap", 5'h06, 8'h01);
    dayEndDoy(8'h23, 8'h00, 8'h99);
    chkReg("R8 hundreds carry hi", 5'h07, 8'h01); chkReg("R8 hundreds carry lo", 5'h06, 8'h00);
    dayEndDoy(8'h12, 8'h03, 8'h65);
    chkReg("R8 leap odd tens", 5'h06, 8'h66);
  endtask

  task automatic testWrites();
    wr(5'h00, 8'h40);
    @(negedge clk); tick = 1'b1; wrEn = 1'b1; addr = 5'h01; wrData = 8'h30;
    @(negedge clk); tick = 1'b0; wrEn = 1'b0;
    chkReg("R9 tick dropped", 5'h00, 8'h00);
    chkReg("R9 sec loaded", 5'h01, 8'h30);
    @(negedge clk); tick = 1'b1; wrEn = 1'b1; addr = 5'h11; wrData = 8'h00;
    @(negedge clk); tick = 1'b0; wrEn = 1'b0;
    chkReg("R9 tick kept on cmp write", 5'h00, 8'h01);
    wr(5'h00, 8'h55); wr(5'h02, 8'h10);
    chkReg("R9 min write clears", 5'h00, 8'h00);
    chkReg("R9 min loaded", 5'h02, 8'h10);
  endtask

  task automatic testAlarm();
    wr(5'h11, 8'h10); wr(5'h12, 8'h05); wr(5'h1E, 8'h06); wr(5'h1F, 8'h00);
    chkReg("R10 cmp read", 5'h11, 8'h10);
    chkReg("R10 mask read", 5'h1E, 8'h06);
    wr(5'h02, 8'h05); wr(5'h01, 8'h09); wr(5'h00, 8'h99);
    chkAlarm("R11 before match", 1'b0);
    ticks(1);
    chkAlarm("R11 match", 1'b1);
    ticks(1);
    chkAlarm("R11 hsec not enabled", 1'b1);
    wr(5'h01, 8'h11);
    chkAlarm("R11 mismatch", 1'b0);
    wr(5'h01, 8'h10);
    chkAlarm("R11 rematch", 1'b1);
    wr(5'h1E, 8'h00);
    chkAlarm("R11 mask zero", 1'b0);
    wr(5'h19, 8'h12); wr(5'h1F, 8'h02);
    chkReg("R10 mask hi read", 5'h1F, 8'h02);
    chkAlarm("R11 year field", 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testHundredths();
    testCascade();
    testDayEnd24();
    testTwelveHour();
    testMonths();
    testDayOfYear();
    testWrites();
    testAlarm();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule